// File: doc/BRIEF.md
# Flash Write-Status Byte Generator

This block produces the byte a flash device returns on its data bus while an internal program or erase is running, or while an erase is suspended. Outside those modes, and for reads that land outside the suspended sectors, it passes array data through unchanged. The host polls this byte to learn three things: whether the operation is still busy, whether it has failed by running past its pulse-count limit, and which sectors are taking part in an erase.

The caller supplies four things. The first is the current operating mode as a 3-bit code. The second is bit 7 of the byte being programmed. The third is a flag saying whether the read address falls in a sector being erased or suspended. The fourth is a timeout flag from the internal engine. A one-cycle read strobe marks each read access; it represents the falling edge of output enable, as sampled by the clock.

Two toggle flops supply the alternating bits: one feeds the busy toggle bit (bit 6) and one feeds the sector toggle bit (bit 2). Each flop advances on qualifying read strobes, not on clock edges. A host that reads twice therefore sees the bit change between the two reads. If the host stops reading, the bit holds its value however many clocks pass.

Top module: `flash_wstat_gen`

## Requirements
- R1: Mode codes are 0 = array read, 1 = program, 2 = erase, 3 = erase-suspended, 4 = program during suspend; codes 5 to 7 behave as code 0. In array-read mode the output equals `array_data`.
- R2: In program mode, bit 7 is the complement of `pgm_d7`, bit 5 equals `timeout`, bit 2 is held at 1, and bits 4, 3, 1 and 0 are 0.
- R3: In modes 1, 2 and 4, bit 6 shows the busy toggle flop. That flop inverts on every read strobe made in those modes, so successive reads alternate. With no strobe it holds its value regardless of clock count.
- R4: In erase mode, bit 7 is 0, bit 3 is 1, bit 5 equals `timeout`, bit 2 shows the sector toggle flop, and bits 4, 1 and 0 are 0.
- R5: The sector toggle flop inverts only on a read strobe with `in_sector` = 1 in mode 2 or mode 3. An erase-mode read with `in_sector` = 0 leaves it unchanged.
- R6: In erase-suspended mode with `in_sector` = 1, the output has bit 7 = 1, bit 6 = 1, bit 5 = 0 even when `timeout` is 1, bit 3 = 0, bit 2 from the sector toggle flop, and bits 4, 1 and 0 = 0. The busy toggle flop does not advance.
- R7: In erase-suspended mode with `in_sector` = 0, the output equals `array_data`, and neither toggle flop advances.
- R8: In program-during-suspend mode, bit 7 is the complement of `pgm_d7`, bit 6 shows the busy toggle flop, bit 5 is 0 even when `timeout` is 1, and bits 4 to 0 are 0.
- R9: After reset both toggle flops are 0. The first status read in program mode shows bit 6 = 0, and the first in erase mode shows bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operating mode code |
| pgm_d7 | input | 1 | Bit 7 of the byte being programmed |
| in_sector | input | 1 | Read address lies in an erasing or suspended sector |
| timeout | input | 1 | Internal pulse-count limit exceeded |
| rd_pulse | input | 1 | One-cycle read access strobe |
| array_data | input | 8 | Array contents at the read address |
| dout | output | 8 | Byte returned to the host |

## Verification
A toggle flop that has been disturbed stays wrong until the next qualifying strobe inverts it, so the error persists. The bench records every read, including reads that must not advance anything, so a missed inversion or an extra one becomes visible. It shows as a wrong bit 6 or bit 2 on the very next status read of the affected kind. A wrong mode decode or bit mapping shows on the same read that exercises it, because every read is compared as a whole byte. An advance that ignores the sector flag shows on the next in-sector erase read.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   typedef enum logic [2:0] {
      FM_ARRAY     = 3'd0,
      FM_PROG      = 3'd1,
      FM_ERASE     = 3'd2,
      FM_SUSP      = 3'd3,
      FM_SUSP_PROG = 3'd4
   } fsg_mode_e;

   localparam int unsigned FSG_NUM_TGL = 2;
   localparam int unsigned FSG_TGL_BUSY = 0;
   localparam int unsigned FSG_TGL_SECT = 1;

   function automatic fsg_mode_e fsg_decode(input logic [2:0] code);
      case (code)
         3'd1:    return FM_PROG;
         3'd2:    return FM_ERASE;
         3'd3:    return FM_SUSP;
         3'd4:    return FM_SUSP_PROG;
         default: return FM_ARRAY;
      endcase
   endfunction
endpackage

// File: rtl/fsg_toggle.sv
module fsg_toggle #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= INIT;
      else if (advance) q <= ~q;
   end

   a_r3_flip_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (q != $past(q)));
   a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(q));
endmodule

// File: rtl/fsg_advance.sv
module fsg_advance
   import fsg_pkg::*;
(
   input  fsg_mode_e                m,
   input  logic                     in_sector,
   input  logic                     rd_pulse,
   output logic [FSG_NUM_TGL-1:0]   adv
);
   logic busy_mode, sect_mode;

   always_comb begin
      busy_mode = (m == FM_PROG) || (m == FM_ERASE) || (m == FM_SUSP_PROG);
      sect_mode = (m == FM_ERASE) || (m == FM_SUSP);
      adv = '0;
      adv[FSG_TGL_BUSY] = rd_pulse && busy_mode;
      adv[FSG_TGL_SECT] = rd_pulse && sect_mode && in_sector;
   end
endmodule

// File: rtl/fsg_compose.sv
module fsg_compose
   import fsg_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned POLL_POS = 7,
   parameter int unsigned TGL_POS  = 6,
   parameter int unsigned FAIL_POS = 5,
   parameter int unsigned TMR_POS  = 3,
   parameter int unsigned ALT_POS  = 2
) (
   input  fsg_mode_e          m,
   input  logic               pgm_d7,
   input  logic               in_sector,
   input  logic               timeout,
   input  logic               t_busy,
   input  logic               t_sect,
   input  logic [DATA_W-1:0]  array_data,
   output logic [DATA_W-1:0]  dout
);
   logic [DATA_W-1:0] st;
   logic              bypass;

   always_comb begin
      st     = '0;
      bypass = 1'b0;
      case (m)
         FM_PROG: begin
            st[POLL_POS] = ~pgm_d7;
            st[TGL_POS]  = t_busy;
            st[FAIL_POS] = timeout;
            st[ALT_POS]  = 1'b1;
         end
         FM_ERASE: begin
            st[TGL_POS]  = t_busy;
            st[FAIL_POS] = timeout;
            st[TMR_POS]  = 1'b1;
            st[ALT_POS]  = t_sect;
         end
         FM_SUSP: begin
            if (in_sector) begin
               st[POLL_POS] = 1'b1;
               st[TGL_POS]  = 1'b1;
               st[ALT_POS]  = t_sect;
            end else begin
               bypass = 1'b1;
            end
         end
         FM_SUSP_PROG: begin
            st[POLL_POS] = ~pgm_d7;
            st[TGL_POS]  = t_busy;
         end
         default: bypass = 1'b1;
      endcase
      dout = bypass ? array_data : st;
   end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
   import fsg_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned POLL_POS = 7,
   parameter int unsigned TGL_POS  = 6,
   parameter int unsigned FAIL_POS = 5,
   parameter int unsigned TMR_POS  = 3,
   parameter int unsigned ALT_POS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              pgm_d7,
   input  logic              in_sector,
   input  logic              timeout,
   input  logic              rd_pulse,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] dout
);
   localparam logic [FSG_NUM_TGL-1:0] TGL_INIT = '0;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("flash_wstat_gen: DATA_W must be at least 8");
      end
      if (POLL_POS >= DATA_W || TGL_POS >= DATA_W || FAIL_POS >= DATA_W ||
          TMR_POS >= DATA_W || ALT_POS >= DATA_W) begin : g_bad_pos
         $error("flash_wstat_gen: status bit position outside data width");
      end
      if (POLL_POS == TGL_POS || POLL_POS == FAIL_POS || POLL_POS == TMR_POS ||
          POLL_POS == ALT_POS || TGL_POS == FAIL_POS || TGL_POS == TMR_POS ||
          TGL_POS == ALT_POS || FAIL_POS == TMR_POS || FAIL_POS == ALT_POS ||
          TMR_POS == ALT_POS) begin : g_bad_overlap
         $error("flash_wstat_gen: status bit positions must be distinct");
      end
   endgenerate

   fsg_mode_e              m;
   logic [FSG_NUM_TGL-1:0] adv;
   logic [FSG_NUM_TGL-1:0] tq;

   assign m = fsg_decode(mode);

   fsg_advance u_adv (
      .m         (m),
      .in_sector (in_sector),
      .rd_pulse  (rd_pulse),
      .adv       (adv)
   );

   for (genvar g = 0; g < FSG_NUM_TGL; g++) begin : g_tgl
      fsg_toggle #(.INIT(TGL_INIT[g])) u_tgl (
         .clk     (clk),
         .rst_n   (rst_n),
         .advance (adv[g]),
         .q       (tq[g])
      );
   end

   fsg_compose #(
      .DATA_W(DATA_W), .POLL_POS(POLL_POS), .TGL_POS(TGL_POS),
      .FAIL_POS(FAIL_POS), .TMR_POS(TMR_POS), .ALT_POS(ALT_POS)
   ) u_cmp (
      .m          (m),
      .pgm_d7     (pgm_d7),
      .in_sector  (in_sector),
      .timeout    (timeout),
      .t_busy     (tq[FSG_TGL_BUSY]),
      .t_sect     (tq[FSG_TGL_SECT]),
      .array_data (array_data),
      .dout       (dout)
   );

   // R1: unknown and array codes pass data
   a_r1_array_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || mode > 3'd4) |-> (dout == array_data));
   // R4: erase keeps the timer bit set and the poll bit clear
   a_r4_erase_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2) |-> (dout[TMR_POS] && !dout[POLL_POS]));
   // R6: suspended sector masks timeout and busy toggle does not move
   a_r6_susp_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && in_sector) |-> (!dout[FAIL_POS] && dout[TGL_POS]));
   a_r6_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3) |=> $stable(tq[FSG_TGL_BUSY]));
   // R7: outside suspended sectors nothing advances
   a_r7_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && !in_sector) |-> (dout == array_data));
   a_r7_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && !in_sector) |=> $stable(tq));
   // R8: timeout masked in program during suspend
   a_r8_fail_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4) |-> !dout[FAIL_POS]);
endmodule

// File: tb/flash_wstat_gen_bench.sv
module flash_wstat_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       pgm_d7 = 1'b0;
   logic       in_sector = 1'b0;
   logic       timeout = 1'b0;
   logic       rd_pulse = 1'b0;
   logic [7:0] array_data = 8'h00;
   logic [7:0] dout;

   int  checks = 0;
   int  failures = 0;
   bit  tb_busy = 1'b0;
   bit  tb_sect = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   flash_wstat_gen u_flash_wstat_gen (
      .clk(clk), .rst_n(rst_n), .mode(mode), .pgm_d7(pgm_d7),
      .in_sector(in_sector), .timeout(timeout), .rd_pulse(rd_pulse),
      .array_data(array_data), .dout(dout)
   );

   function automatic logic [7:0] exp_byte(input logic [2:0] md, input logic d7,
      input logic sec, input logic to, input logic [7:0] arr,
      input logic b6, input logic b2);
      logic [7:0] e;
      e = 8'h00;
      case (md)
         3'd1: begin e[7] = ~d7; e[6] = b6; e[5] = to; e[2] = 1'b1; end
         3'd2: begin e[6] = b6; e[5] = to; e[3] = 1'b1; e[2] = b2; end
         3'd3: if (sec) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = b2; end
               else e = arr;
         3'd4: begin e[7] = ~d7; e[6] = b6; end
         default: e = arr;
      endcase
      return e;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_read(input logic [2:0] md, input logic d7, input logic sec,
      input logic to, input logic [7:0] arr, input string tag);
      @(negedge clk);
      mode = md; pgm_d7 = d7; in_sector = sec; timeout = to; array_data = arr;
      #1;
      check(tag, dout, exp_byte(md, d7, sec, to, arr, tb_busy, tb_sect));
      rd_pulse = 1'b1;
      @(negedge clk);
      rd_pulse = 1'b0;
      if (md == 3'd1 || md == 3'd2 || md == 3'd4) tb_busy = ~tb_busy;
      if ((md == 3'd2 || md == 3'd3) && sec) tb_sect = ~tb_sect;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state of both toggles
      do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 first program read bit6=0");
      do_read(3'd2, 1'b0, 1'b1, 1'b0, 8'h00, "R9 first erase read bit2=0");
      // R1: array passthrough, incl. undefined codes
      do_read(3'd0, 1'b1, 1'b1, 1'b1, 8'hA5, "R1 array read");
      do_read(3'd6, 1'b0, 1'b0, 1'b1, 8'h3C, "R1 undefined code");
      // R2 and R3: program alternates; no advance without strobe
      do_read(3'd1, 1'b1, 1'b0, 1'b0, 8'hFF, "R2 program d7=1");
      do_read(3'd1, 1'b0, 1'b0, 1'b1, 8'hFF, "R2 program timeout");
      idle(17);
      do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'hFF, "R3 hold across idle clocks");
      // R4 and R5: erase, outside-sector reads leave bit2
      do_read(3'd2, 1'b0, 1'b0, 1'b1, 8'h00, "R4 erase timeout");
      do_read(3'd2, 1'b0, 1'b0, 1'b0, 8'h00, "R5 erase outside sector");
      do_read(3'd2, 1'b0, 1'b1, 1'b0, 8'h00, "R5 erase inside sector");
      // R6: suspend in sector, timeout masked
      do_read(3'd3, 1'b0, 1'b1, 1'b1, 8'h12, "R6 suspend sector timeout");
      do_read(3'd3, 1'b0, 1'b1, 1'b0, 8'h12, "R6 suspend sector toggle");
      // R7: suspend outside sector, then confirm toggles unmoved
      do_read(3'd3, 1'b0, 1'b0, 1'b1, 8'h5A, "R7 suspend outside array");
      do_read(3'd3, 1'b0, 1'b0, 1'b0, 8'hC3, "R7 suspend outside array 2");
      do_read(3'd2, 1'b0, 1'b1, 1'b0, 8'h00, "R7 toggles unchanged after");
      // R8: program during suspend
      do_read(3'd4, 1'b0, 1'b1, 1'b1, 8'hFF, "R8 suspend program timeout");
      do_read(3'd4, 1'b1, 1'b0, 1'b0, 8'hFF, "R8 suspend program");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [2:0] md;
         md = 3'($urandom_range(0, 7));
         do_read(md, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                 "R1-mix random read (R3 R5 R6 R7 R8)");
         if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 5)));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule